// File: doc/BRIEF.md
# Four-Accumulator Pipelined Multiply-Accumulate Engine

This engine multiplies two 16-bit operands and adds the product into one of four 48-bit accumulators. Each operand is taken from either the upper or the lower half of its own 32-bit source word, so that two data words can feed a run of multiplies while the half selection alternates between operations. The multiply path has four stages and takes one new operation every cycle. Results stay inside the accumulators. A separate read port returns an accumulator as a 32-bit word plus a 16-bit extension.

A 2-bit mode input selects signed integer, signed fractional or unsigned integer arithmetic. The mode also sets how the word and the extension map onto the full 48-bit value. In the integer modes the extension sits above the word. In fractional mode the extension is split, with its high byte above the word and its low byte below it.

A load port writes the word and the extension of one accumulator. The load travels down the same stage chain as the multiplies, so it lands after any earlier operation to that accumulator. A read of an accumulator that still has work in flight is held off by a not-ready indication.

Top module: `mac_quad`

## Requirements
- R1: There are four accumulators selected by a 2-bit index, each 48 bits wide. Reset clears all of them to zero. An accumulator that no retiring operation targets keeps its value.
- R2: Each operand has a select bit: 1 takes bits [31:16] of its source word, 0 takes bits [15:0].
- R3: Mode 00 (signed integer) forms the signed 32-bit product, sign-extends it to 48 bits and adds it. On read and load, word = full[31:0] and extension = full[47:32].
- R4: Mode 01 (signed fractional) sign-extends the signed product, shifts it left by one bit and adds it. On read and load, word = full[39:8] and extension = {full[47:40], full[7:0]}.
- R5: Mode 10 (unsigned integer) zero-extends the unsigned product and adds it. The word and extension layout is the same as in R3.
- R6: Mode 11 behaves exactly as mode 00.
- R7: An operation issued in cycle c changes its accumulator at the fourth rising edge counted from the edge that ends cycle c. Operations may issue every cycle, and back-to-back operations to the same accumulator are all accumulated.
- R8: rd_ready is high only when rd_req is high and no issued operation or load to accumulator rd_acc is still in flight. A read of a different accumulator is ready at once. rd_word and rd_ext are valid while rd_ready is high.
- R9: A load writes the word and extension under the mode current at issue. It has the same latency as an operation and is ordered with operations to the same accumulator.
- R10: When op_valid and wr_valid are both high, the operation is taken and the load is ignored.
- R11: Accumulation wraps modulo 2^48, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Arithmetic mode: 00 signed int, 01 signed fractional, 10 unsigned int, 11 as 00 |
| op_valid | input | 1 | Issue a multiply-accumulate this cycle |
| op_acc | input | 2 | Target accumulator of the operation |
| op_src_a | input | 32 | First source word |
| op_src_b | input | 32 | Second source word |
| op_hi_a | input | 1 | Take upper half of op_src_a when 1 |
| op_hi_b | input | 1 | Take upper half of op_src_b when 1 |
| wr_valid | input | 1 | Issue an accumulator load this cycle |
| wr_acc | input | 2 | Target accumulator of the load |
| wr_word | input | 32 | Word value to load |
| wr_ext | input | 16 | Extension value to load |
| rd_req | input | 1 | Read request |
| rd_acc | input | 2 | Accumulator to read |
| rd_ready | output | 1 | Read data valid, no pending update to rd_acc |
| rd_word | output | 32 | Word view of the selected accumulator |
| rd_ext | output | 16 | Extension view of the selected accumulator |

## Verification
The main function is swept over a grid of corner operand values: zero, one, the largest positive, the most negative, all-ones and a mixed pattern. The grid is run in all four mode codes, with the half-select bits and the target accumulator changing from one operation to the next, and issued back-to-back. This separates signed from unsigned products, catches a missing or misplaced fractional shift, shows a wrong half or an operand swap, and exposes a lost update when operations to one accumulator are only cycles apart. Fractional-mode loads read back in integer mode show the split extension layout. Loads placed before and after in-flight operations, and a load issued together with an operation, show ordering and priority. Values set just below the 48-bit limit show wraparound. A per-cycle read of an accumulator with a pending update, set against a read of an idle one, shows the stall window.

// File: rtl/mac_quad_pkg.sv
package mac_quad_pkg;
  localparam int HALF_W    = 16;
  localparam int WORD_W    = 2 * HALF_W;
  localparam int EXT_W     = 16;
  localparam int FULL_W    = WORD_W + EXT_W;
  localparam int ACC_COUNT = 4;
  localparam int IDX_W     = $clog2(ACC_COUNT);
  localparam int MUL_STAGES = 3;
  localparam int EXT_HALF  = EXT_W / 2;

  typedef enum logic [1:0] {
    MODE_SINT  = 2'b00,
    MODE_SFRAC = 2'b01,
    MODE_UINT  = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;

  typedef logic [FULL_W-1:0] full_t;

  typedef struct packed {
    logic             valid;
    logic             is_load;
    logic [IDX_W-1:0] idx;
    mode_e            mode;
    full_t            data;
  } stage_t;

  function automatic mode_e norm_mode(input logic [1:0] m);
    return (m == 2'b11) ? MODE_SINT : mode_e'(m);
  endfunction

  function automatic logic [HALF_W-1:0] pick_half(input logic [WORD_W-1:0] src,
                                                  input logic hi);
    return hi ? src[WORD_W-1:HALF_W] : src[HALF_W-1:0];
  endfunction

  function automatic full_t pack_full(input mode_e m, input logic [WORD_W-1:0] w,
                                      input logic [EXT_W-1:0] e);
    if (m == MODE_SFRAC) return {e[EXT_W-1:EXT_HALF], w, e[EXT_HALF-1:0]};
    return {e, w};
  endfunction

  function automatic logic [WORD_W-1:0] word_view(input mode_e m, input full_t f);
    if (m == MODE_SFRAC) return f[WORD_W+EXT_HALF-1:EXT_HALF];
    return f[WORD_W-1:0];
  endfunction

  function automatic logic [EXT_W-1:0] ext_view(input mode_e m, input full_t f);
    if (m == MODE_SFRAC) return {f[FULL_W-1:WORD_W+EXT_HALF], f[EXT_HALF-1:0]};
    return f[FULL_W-1:WORD_W];
  endfunction

  function automatic logic [WORD_W-1:0] mul_halves(input mode_e m,
                                                   input logic [HALF_W-1:0] a,
                                                   input logic [HALF_W-1:0] b);
    logic signed [WORD_W-1:0] sa, sb;
    if (m == MODE_UINT) return {{HALF_W{1'b0}}, a} * {{HALF_W{1'b0}}, b};
    sa = {{HALF_W{a[HALF_W-1]}}, a};
    sb = {{HALF_W{b[HALF_W-1]}}, b};
    return sa * sb;
  endfunction

  function automatic full_t widen_product(input mode_e m, input logic [WORD_W-1:0] p);
    case (m)
      MODE_UINT:  return {{EXT_W{1'b0}}, p};
      MODE_SFRAC: return {{(EXT_W-1){p[WORD_W-1]}}, p, 1'b0};
      default:    return {{EXT_W{p[WORD_W-1]}}, p};
    endcase
  endfunction
endpackage

// File: rtl/mac_quad_issue.sv
module mac_quad_issue
  import mac_quad_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic              op_valid,
  input  logic [IDX_W-1:0]  op_acc,
  input  logic [WORD_W-1:0] op_src_a,
  input  logic [WORD_W-1:0] op_src_b,
  input  logic              op_hi_a,
  input  logic              op_hi_b,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  wr_acc,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [EXT_W-1:0]  wr_ext,
  output stage_t            issue
);
  mode_e m_now;
  assign m_now = norm_mode(mode);

  always_comb begin
    issue = '0;
    if (op_valid) begin
      issue.valid   = 1'b1;
      issue.is_load = 1'b0;
      issue.idx     = op_acc;
      issue.mode    = m_now;
      issue.data    = {{EXT_W{1'b0}}, pick_half(op_src_a, op_hi_a),
                       pick_half(op_src_b, op_hi_b)};
    end else if (wr_valid) begin
      issue.valid   = 1'b1;
      issue.is_load = 1'b1;
      issue.idx     = wr_acc;
      issue.mode    = m_now;
      issue.data    = pack_full(m_now, wr_word, wr_ext);
    end
  end
endmodule

// File: rtl/mac_quad_stage.sv
module mac_quad_stage
  import mac_quad_pkg::*;
#(
  parameter int STEP = 0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  stage_t d,
  output stage_t q
);
  stage_t nxt;

  generate
    if (STEP == 1) begin : g_mul
      always_comb begin
        nxt = d;
        if (d.valid && !d.is_load)
          nxt.data = {{EXT_W{1'b0}},
                      mul_halves(d.mode, d.data[WORD_W-1:HALF_W], d.data[HALF_W-1:0])};
      end
    end else if (STEP == 2) begin : g_widen
      always_comb begin
        nxt = d;
        if (d.valid && !d.is_load)
          nxt.data = widen_product(d.mode, d.data[WORD_W-1:0]);
      end
    end else begin : g_pass
      assign nxt = d;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/mac_quad_accbank.sv
module mac_quad_accbank
  import mac_quad_pkg::*;
#(
  parameter int NUM_ACC = ACC_COUNT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  stage_t                    upd,
  input  logic [1:0]                mode,
  input  logic [IDX_W-1:0]          rd_acc,
  output logic [WORD_W-1:0]         rd_word,
  output logic [EXT_W-1:0]          rd_ext,
  output logic [NUM_ACC*FULL_W-1:0] acc_flat
);
  full_t acc_q [NUM_ACC];
  mode_e m_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ACC; i++) acc_q[i] <= '0;
    end else if (upd.valid) begin
      if (upd.is_load) acc_q[upd.idx] <= upd.data;
      else             acc_q[upd.idx] <= acc_q[upd.idx] + upd.data;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_ACC; g++) begin : g_flat
      assign acc_flat[g*FULL_W +: FULL_W] = acc_q[g];
    end
  endgenerate

  assign m_rd    = norm_mode(mode);
  assign rd_word = word_view(m_rd, acc_q[rd_acc]);
  assign rd_ext  = ext_view(m_rd, acc_q[rd_acc]);
endmodule

// File: rtl/mac_quad.sv
module mac_quad
  import mac_quad_pkg::*;
#(
  parameter int NUM_ACC = ACC_COUNT,
  parameter int STAGES  = MUL_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              op_valid,
  input  logic [1:0]        op_acc,
  input  logic [31:0]       op_src_a,
  input  logic [31:0]       op_src_b,
  input  logic              op_hi_a,
  input  logic              op_hi_b,
  input  logic              wr_valid,
  input  logic [1:0]        wr_acc,
  input  logic [31:0]       wr_word,
  input  logic [15:0]       wr_ext,
  input  logic              rd_req,
  input  logic [1:0]        rd_acc,
  output logic              rd_ready,
  output logic [31:0]       rd_word,
  output logic [15:0]       rd_ext
);
  stage_t pipe [STAGES+1];

  mac_quad_issue u_issue (
    .mode(mode), .op_valid(op_valid), .op_acc(op_acc),
    .op_src_a(op_src_a), .op_src_b(op_src_b),
    .op_hi_a(op_hi_a), .op_hi_b(op_hi_b),
    .wr_valid(wr_valid), .wr_acc(wr_acc), .wr_word(wr_word), .wr_ext(wr_ext),
    .issue(pipe[0])
  );

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      mac_quad_stage #(.STEP(k)) u_stage (
        .clk(clk), .rst_n(rst_n), .d(pipe[k]), .q(pipe[k+1])
      );
    end
  endgenerate

  // named events for the checker
  logic                      issue_valid, issue_is_load, ret_valid;
  logic [IDX_W-1:0]          issue_idx, ret_idx;
  logic [NUM_ACC*FULL_W-1:0] acc_flat;
  logic                      rd_pending;

  assign issue_valid   = pipe[0].valid;
  assign issue_is_load = pipe[0].is_load;
  assign issue_idx     = pipe[0].idx;
  assign ret_valid     = pipe[STAGES].valid;
  assign ret_idx       = pipe[STAGES].idx;

  always_comb begin
    rd_pending = 1'b0;
    for (int s = 1; s <= STAGES; s++)
      if (pipe[s].valid && pipe[s].idx == rd_acc) rd_pending = 1'b1;
  end

  mac_quad_accbank #(.NUM_ACC(NUM_ACC)) u_bank (
    .clk(clk), .rst_n(rst_n), .upd(pipe[STAGES]), .mode(mode),
    .rd_acc(rd_acc), .rd_word(rd_word), .rd_ext(rd_ext), .acc_flat(acc_flat)
  );

  assign rd_ready = rd_req && !rd_pending;
endmodule

// File: rtl/mac_quad_chk.sv
module mac_quad_chk
  import mac_quad_pkg::*;
#(
  parameter int NUM_ACC = ACC_COUNT
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      op_valid,
  input logic [1:0]                op_acc,
  input logic                      wr_valid,
  input logic                      rd_req,
  input logic [1:0]                rd_acc,
  input logic                      rd_ready,
  input logic                      issue_valid,
  input logic                      issue_is_load,
  input logic [IDX_W-1:0]          issue_idx,
  input logic                      ret_valid,
  input logic [IDX_W-1:0]          ret_idx,
  input logic [NUM_ACC*FULL_W-1:0] acc_flat
);
  assert_ready_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> rd_req);

  assert_busy_after_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !(rd_req && rd_ready && rd_acc == $past(op_acc)));

  assert_op_beats_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && wr_valid) |-> (issue_valid && !issue_is_load && issue_idx == op_acc));

  assert_retire_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> ($past(issue_valid, 3) && $past(issue_idx, 3) == ret_idx));

  assert_idle_no_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> ##3 !ret_valid);

  genvar g;
  generate
    for (g = 0; g < NUM_ACC; g++) begin : g_hold
      assert_untouched_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(ret_valid && ret_idx == g) |=> $stable(acc_flat[g*FULL_W +: FULL_W]));
    end
  endgenerate
endmodule

bind mac_quad mac_quad_chk #(.NUM_ACC(NUM_ACC)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_acc(op_acc),
  .wr_valid(wr_valid), .rd_req(rd_req), .rd_acc(rd_acc), .rd_ready(rd_ready),
  .issue_valid(issue_valid), .issue_is_load(issue_is_load), .issue_idx(issue_idx),
  .ret_valid(ret_valid), .ret_idx(ret_idx), .acc_flat(acc_flat)
);

// File: tb/tb_mac_quad.sv
`timescale 1ns/1ps
module tb_mac_quad;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        op_valid = 1'b0;
  logic [1:0]  op_acc = '0;
  logic [31:0] op_src_a = '0, op_src_b = '0;
  logic        op_hi_a = 1'b0, op_hi_b = 1'b0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_acc = '0;
  logic [31:0] wr_word = '0;
  logic [15:0] wr_ext = '0;
  logic        rd_req = 1'b0;
  logic [1:0]  rd_acc = '0;
  logic        rd_ready;
  logic [31:0] rd_word;
  logic [15:0] rd_ext;

  int tests = 0, fails = 0;
  logic [47:0] model [4];
  bit done = 0;

  always #2 clk = ~clk;

  mac_quad dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .op_valid(op_valid), .op_acc(op_acc),
    .op_src_a(op_src_a), .op_src_b(op_src_b), .op_hi_a(op_hi_a), .op_hi_b(op_hi_b),
    .wr_valid(wr_valid), .wr_acc(wr_acc), .wr_word(wr_word), .wr_ext(wr_ext),
    .rd_req(rd_req), .rd_acc(rd_acc), .rd_ready(rd_ready),
    .rd_word(rd_word), .rd_ext(rd_ext)
  );

  function automatic logic [47:0] prod48(input logic [1:0] m, input logic [15:0] a,
                                         input logic [15:0] b);
    longint p;
    if (m == 2'b10) p = longint'(a) * longint'(b);
    else begin
      p = longint'($signed(a)) * longint'($signed(b));
      if (m == 2'b01) p = p * 2;
    end
    return p[47:0];
  endfunction

  function automatic logic [47:0] load48(input logic [1:0] m, input logic [31:0] w,
                                         input logic [15:0] e);
    if (m == 2'b01) return {e[15:8], w, e[7:0]};
    return {e, w};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue_mac(input int n, input logic [15:0] a, input logic [15:0] b,
                           input bit ha, input bit hb);
    @(negedge clk);
    wr_valid = 1'b0;
    op_valid = 1'b1; op_acc = n[1:0]; op_hi_a = ha; op_hi_b = hb;
    op_src_a = ha ? {a, ~a} : {~a, a};
    op_src_b = hb ? {b, b ^ 16'h5A5A} : {b ^ 16'hA5A5, b};
    @(posedge clk);
    model[n] = model[n] + prod48(mode, a, b);
  endtask

  task automatic issue_load(input int n, input logic [31:0] w, input logic [15:0] e);
    @(negedge clk);
    op_valid = 1'b0;
    wr_valid = 1'b1; wr_acc = n[1:0]; wr_word = w; wr_ext = e;
    @(posedge clk);
    model[n] = load48(mode, w, e);
  endtask

  task automatic drain();
    @(negedge clk);
    op_valid = 1'b0; wr_valid = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic check_acc(input int n, input string req);
    logic [31:0] ew;
    logic [15:0] ee;
    @(negedge clk);
    rd_req = 1'b1; rd_acc = n[1:0];
    #1;
    if (mode == 2'b01) begin
      ew = model[n][39:8]; ee = {model[n][47:40], model[n][7:0]};
    end else begin
      ew = model[n][31:0]; ee = model[n][47:32];
    end
    check(rd_ready && rd_word === ew && rd_ext === ee, req,
          {15'b0, rd_ready, rd_ext, rd_word}, {15'b0, 1'b1, ee, ew});
    rd_req = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [15:0] vals [6];
    vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    for (int n = 0; n < 4; n++) check_acc(n, "R1 reset");

    // R2/R3/R4/R5/R6/R7: back-to-back sweep over corner operands in every mode
    for (int m = 0; m < 4; m++) begin
      @(negedge clk) mode = m[1:0];
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          issue_mac((i + j) % 4, vals[i], vals[j], j[0], i[0]);
      drain();
      for (int n = 0; n < 4; n++)
        check_acc(n, m == 0 ? "R2 R3 R7 sint" : m == 1 ? "R2 R4 R7 sfrac" :
                     m == 2 ? "R2 R5 R7 uint" : "R2 R6 R7 mode11");
    end

    // R8: stall window on the target accumulator only
    @(negedge clk) mode = 2'b00;
    issue_mac(2, 16'h0003, 16'h0005, 1'b0, 1'b1);
    @(negedge clk);
    op_valid = 1'b0;
    for (int s = 0; s < 3; s++) begin
      if (s > 0) @(negedge clk);
      rd_req = 1'b1; rd_acc = 2'd2; #0.5;
      check(!rd_ready, "R8 pending stall", {63'b0, rd_ready}, 64'd0);
      rd_acc = 2'd1; #0.5;
      check(rd_ready, "R8 other ready", {63'b0, rd_ready}, 64'd1);
      rd_req = 1'b0; #0.5;
      check(!rd_ready, "R8 no req", {63'b0, rd_ready}, 64'd0);
    end
    check_acc(2, "R8 ready after retire");

    // R9: load ordered after an in-flight op, then op after load
    issue_mac(3, 16'h0100, 16'h0100, 1'b1, 1'b0);
    issue_load(3, 32'hDEADBEEF, 16'h0042);
    issue_load(0, 32'h00000010, 16'h0000);
    issue_mac(0, 16'hFFFE, 16'h0003, 1'b0, 1'b0);
    drain();
    check_acc(3, "R9 load after op");
    check_acc(0, "R9 op after load");

    // R4: fractional load layout seen through the integer view
    @(negedge clk) mode = 2'b01;
    issue_load(1, 32'h89ABCDEF, 16'h1234);
    drain();
    @(negedge clk) mode = 2'b00;
    check_acc(1, "R4 split extension");
    @(negedge clk) rd_req = 1'b1; rd_acc = 2'd1; #1;
    check(rd_word === 32'hABCDEF34 && rd_ext === 16'h1289, "R4 layout literal",
          {16'b0, rd_ext, rd_word}, {16'b0, 16'h1289, 32'hABCDEF34});
    rd_req = 1'b0;

    // R10: simultaneous op and load, load ignored
    @(negedge clk);
    op_valid = 1'b1; op_acc = 2'd1; op_hi_a = 1'b0; op_hi_b = 1'b0;
    op_src_a = 32'h00000007; op_src_b = 32'h00000006;
    wr_valid = 1'b1; wr_acc = 2'd1; wr_word = 32'h0; wr_ext = 16'h0;
    @(posedge clk);
    model[1] = model[1] + prod48(mode, 16'd7, 16'd6);
    drain();
    check_acc(1, "R10 load dropped");

    // R11: wraparound
    issue_load(0, 32'hFFFFFFFF, 16'h7FFF);
    issue_mac(0, 16'h0001, 16'h0001, 1'b0, 1'b0);
    drain();
    @(negedge clk) rd_req = 1'b1; rd_acc = 2'd0; #1;
    check(rd_word === 32'h0 && rd_ext === 16'h8000, "R11 signed wrap",
          {16'b0, rd_ext, rd_word}, {16'b0, 16'h8000, 32'h0});
    rd_req = 1'b0;
    @(negedge clk) mode = 2'b10;
    issue_load(2, 32'hFFFFFFFF, 16'hFFFF);
    issue_mac(2, 16'h0001, 16'h0001, 1'b1, 1'b1);
    drain();
    @(negedge clk) rd_req = 1'b1; rd_acc = 2'd2; #1;
    check(rd_word === 32'h0 && rd_ext === 16'h0, "R11 unsigned wrap",
          {16'b0, rd_ext, rd_word}, 64'h0);
    rd_req = 1'b0;

    done = 1;
    summary();
  end
endmodule